// File: doc/BRIEF.md
# Segment Descriptor Cache with Limit Checking

This block holds a hidden descriptor cache for four segment registers (extra, code, stack, data). Each entry holds a base, a limit, a privilege level, a code-type bit, a writable bit and an entry-valid bit. Every memory access names a segment, an offset, a size (byte or word) and a direction. In the same cycle the block returns the 24-bit linear address or a fault with its interrupt vector. The same limit logic serves both operating modes, so the real mode behaves as a reduced form of the protected mode.

A load port rewrites one segment register. In real mode the load runs no validation and finishes at the next clock edge. It derives the entry from the selector alone. In protected mode the descriptor arrives on dedicated inputs along with the selector. It is checked against the current privilege level over a fixed multi-cycle window, and a busy flag is high for that window. Cache entries survive a mode change, so a large limit set in protected mode stays in force after a return to real mode until that register is reloaded.

Top module: `seg_shadow_unit`

## Requirements
- R1: After reset all four entries are valid and writable with limit 0xFFFF. The extra, stack and data entries have base 0; the code entry has base 0xFF0000. The current privilege level is 0, and busy and done are low.
- R2: An access with no fault returns linear address = base + offset modulo 2^24 in the same cycle, with fault low. A faulting access returns address 0.
- R3: An access faults when its last byte (offset, or offset+1 for a word) is above the cached limit. A word access at offset 0xFFFF under limit 0xFFFF therefore faults.
- R4: Segment index encoding is extra=0, code=1, stack=2, data=3. A limit fault through the stack segment gives vector 0x0C. A limit fault through any other segment gives vector 0x0D.
- R5: A real-mode load sets base = selector × 16, limit = 0xFFFF, writable, not code, valid. It updates the cache at the accepting edge and raises done in the next cycle without ever raising busy.
- R6: A protected-mode load holds busy high for exactly PM_LAT cycles after the accepting edge. Done rises as busy falls. The target entry keeps its old value while busy is high.
- R7: A protected load fails with done high, fault high and vector 0x0D, and leaves the cache unchanged, when it breaks a privilege rule. Let E = max(CPL, RPL), where RPL is selector bits [1:0]. The rules are: data or extra needs DPL ≥ E; code needs code type and DPL ≥ E; stack needs writable non-code, DPL = CPL and RPL = CPL.
- R8: A null selector (bits [15:2] all zero) loaded in protected mode succeeds for data or extra and marks the entry invalid. Any later access through that entry faults with vector 0x0D. A null selector for code or stack fails the load.
- R9: In protected mode a write through an entry that is code type, or that is not writable, faults with vector 0x0D. In real mode no write check is made.
- R10: Switching to real mode keeps every cached entry, including limits above 0xFFFF, until the register is reloaded.
- R11: A successful protected load of the code register sets the current privilege level to the descriptor's DPL.
- R12: A load request presented while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_mode | input | 1 | 1 = protected mode, 0 = real mode |
| ld_valid | input | 1 | Load request |
| ld_seg | input | 2 | Target segment index |
| ld_sel | input | 16 | Selector value |
| dsc_base | input | 24 | Supplied descriptor base (protected) |
| dsc_limit | input | 24 | Supplied descriptor limit (protected) |
| dsc_dpl | input | 2 | Supplied descriptor privilege level |
| dsc_code | input | 1 | Supplied descriptor is code type |
| dsc_writable | input | 1 | Supplied descriptor is writable |
| ld_busy | output | 1 | Protected load in progress |
| ld_done | output | 1 | One-cycle pulse: load finished |
| ld_fault | output | 1 | With ld_done: load rejected |
| ld_vector | output | 8 | Vector of a rejected load |
| acc_valid | input | 1 | Access request |
| acc_seg | input | 2 | Access segment index |
| acc_off | input | OFF_W | Access offset |
| acc_word | input | 1 | 1 = two-byte access |
| acc_write | input | 1 | 1 = write access |
| acc_lin | output | 24 | Linear address |
| acc_fault | output | 1 | Access fault |
| acc_vector | output | 8 | Vector of the access fault |
| cur_cpl | output | 2 | Current privilege level |

## Verification
The assertions take two things for granted. Descriptor inputs are held stable while a load is being accepted. The access request fields are settled before the edge on which a property samples them. The bench changes every input only at the falling edge and holds the descriptor bus constant for the whole busy window, so both hold. Load requests made during busy change only the segment index and selector, so the rejection of a second request (R12) can be seen at the ports without breaking what the pending load uses.

// File: rtl/segchk_pkg.sv
package segchk_pkg;
  localparam int LIN_W     = 24;
  localparam int SEL_W     = 16;
  localparam int NSEG      = 4;
  localparam int SEG_IDX_W = $clog2(NSEG);

  localparam logic [SEG_IDX_W-1:0] SEG_EXTRA = 2'd0;
  localparam logic [SEG_IDX_W-1:0] SEG_CODE  = 2'd1;
  localparam logic [SEG_IDX_W-1:0] SEG_STACK = 2'd2;
  localparam logic [SEG_IDX_W-1:0] SEG_DATA  = 2'd3;

  localparam logic [7:0] VEC_STACK = 8'h0C;
  localparam logic [7:0] VEC_PROT  = 8'h0D;

  localparam logic [LIN_W-1:0] REAL_LIMIT = LIN_W'(16'hFFFF);

  typedef struct packed {
    logic [LIN_W-1:0] base;
    logic [LIN_W-1:0] limit;
    logic [1:0]       dpl;
    logic             code;
    logic             wr;
    logic             valid;
  } seg_entry_t;

  // Entry built from a selector alone, as the real mode does.
  function automatic seg_entry_t real_entry(input logic [SEL_W-1:0] sel);
    seg_entry_t e;
    e.base  = LIN_W'({sel, 4'h0});
    e.limit = REAL_LIMIT;
    e.dpl   = 2'd0;
    e.code  = 1'b0;
    e.wr    = 1'b1;
    e.valid = 1'b1;
    return e;
  endfunction

  // Wrap-around sum of base and offset.
  function automatic logic [LIN_W-1:0] lin_sum(input logic [LIN_W-1:0] base,
                                               input logic [LIN_W-1:0] off);
    return base + off;
  endfunction

  // True when the last byte touched lies above the limit.
  function automatic logic past_limit(input logic [LIN_W-1:0] off,
                                      input logic             word,
                                      input logic [LIN_W-1:0] limit);
    logic [LIN_W:0] last;
    last = {1'b0, off} + {{LIN_W{1'b0}}, word};
    return last > {1'b0, limit};
  endfunction

  // Privilege and type rules for a protected load.
  function automatic logic load_allowed(input logic [SEG_IDX_W-1:0] seg,
                                        input logic                 is_null,
                                        input logic [1:0]           rpl,
                                        input logic [1:0]           dpl,
                                        input logic                 code,
                                        input logic                 wr,
                                        input logic [1:0]           cpl);
    logic [1:0] eff;
    logic       ok;
    eff = (rpl > cpl) ? rpl : cpl;
    if (is_null) begin
      ok = (seg == SEG_DATA) || (seg == SEG_EXTRA);
    end else begin
      case (seg)
        SEG_CODE:  ok = code && (dpl >= eff);
        SEG_STACK: ok = !code && wr && (dpl == cpl) && (rpl == cpl);
        default:   ok = (dpl >= eff);
      endcase
    end
    return ok;
  endfunction
endpackage

// File: rtl/seg_load_ctrl.sv
module seg_load_ctrl
  import segchk_pkg::*;
#(
  parameter int PM_LAT = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 prot_mode,
  input  logic                 ld_valid,
  input  logic [SEG_IDX_W-1:0] ld_seg,
  input  logic [SEL_W-1:0]     ld_sel,
  input  logic [LIN_W-1:0]     dsc_base,
  input  logic [LIN_W-1:0]     dsc_limit,
  input  logic [1:0]           dsc_dpl,
  input  logic                 dsc_code,
  input  logic                 dsc_writable,
  output logic                 busy,
  output logic                 done,
  output logic                 fault,
  output logic [1:0]           cpl,
  output logic                 wr_en,
  output logic [SEG_IDX_W-1:0] wr_idx,
  output seg_entry_t           wr_data
);
  localparam int CNT_W = (PM_LAT > 1) ? $clog2(PM_LAT) : 1;

  logic                 busy_q, done_q, fault_q;
  logic [1:0]           cpl_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [SEG_IDX_W-1:0] p_seg;
  logic [SEL_W-1:0]     p_sel;
  seg_entry_t           p_ent;

  // Named internal events
  logic accept, real_load, prot_start, prot_finish, p_null, p_ok;

  assign accept      = ld_valid && !busy_q;
  assign real_load   = accept && !prot_mode;
  assign prot_start  = accept && prot_mode;
  assign prot_finish = busy_q && (cnt_q == '0);
  assign p_null      = (p_sel[SEL_W-1:2] == '0);
  assign p_ok        = load_allowed(p_seg, p_null, p_sel[1:0], p_ent.dpl,
                                    p_ent.code, p_ent.wr, cpl_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      cpl_q   <= 2'd0;
      cnt_q   <= '0;
      p_seg   <= '0;
      p_sel   <= '0;
      p_ent   <= '0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      if (real_load) begin
        done_q <= 1'b1;
      end
      if (prot_start) begin
        busy_q      <= 1'b1;
        cnt_q       <= CNT_W'(PM_LAT - 1);
        p_seg       <= ld_seg;
        p_sel       <= ld_sel;
        p_ent.base  <= dsc_base;
        p_ent.limit <= dsc_limit;
        p_ent.dpl   <= dsc_dpl;
        p_ent.code  <= dsc_code;
        p_ent.wr    <= dsc_writable;
        p_ent.valid <= 1'b1;
      end else if (prot_finish) begin
        busy_q  <= 1'b0;
        done_q  <= 1'b1;
        fault_q <= !p_ok;
        if (p_ok && (p_seg == SEG_CODE)) cpl_q <= p_ent.dpl;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_comb begin
    wr_en   = real_load || (prot_finish && p_ok);
    wr_idx  = real_load ? ld_seg : p_seg;
    wr_data = real_load ? real_entry(ld_sel) : p_ent;
    if (!real_load && p_null) wr_data.valid = 1'b0;
  end

  assign busy  = busy_q;
  assign done  = done_q;
  assign fault = fault_q;
  assign cpl   = cpl_q;

  a_r5_real_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !busy && !prot_mode) |=> (done && !busy));
  a_r6_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r12_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q != '0) |=> (busy && $stable(p_seg) && $stable(p_sel)));
endmodule

// File: rtl/seg_cache.sv
module seg_cache
  import segchk_pkg::*;
#(
  parameter logic [LIN_W-1:0] CODE_RST_BASE = 24'hFF0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SEG_IDX_W-1:0] wr_idx,
  input  seg_entry_t           wr_data,
  input  logic [SEG_IDX_W-1:0] rd_idx,
  output seg_entry_t           rd_data,
  input  logic                 ld_fault_ev
);
  seg_entry_t [NSEG-1:0] ent_q;

  for (genvar i = 0; i < NSEG; i++) begin : g_ent
    seg_entry_t rst_val;
    always_comb begin
      rst_val = real_entry('0);
      if (SEG_IDX_W'(i) == SEG_CODE) rst_val.base = CODE_RST_BASE;
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_q[i] <= rst_val;
      end else if (wr_en && (wr_idx == SEG_IDX_W'(i))) begin
        ent_q[i] <= wr_data;
      end
    end
  end

  assign rd_data = ent_q[rd_idx];

  a_r7_cache_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fault_ev |-> $stable(ent_q));
endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
  import segchk_pkg::*;
#(
  parameter int OFF_W = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 prot_mode,
  input  logic                 acc_valid,
  input  logic [SEG_IDX_W-1:0] acc_seg,
  input  logic [OFF_W-1:0]     acc_off,
  input  logic                 acc_word,
  input  logic                 acc_write,
  input  logic [LIN_W-1:0]     ent_base,
  input  logic [LIN_W-1:0]     ent_limit,
  input  logic                 ent_code,
  input  logic                 ent_wr,
  input  logic                 ent_valid,
  output logic [LIN_W-1:0]     acc_lin,
  output logic                 acc_fault,
  output logic [7:0]           acc_vector
);
  logic [LIN_W-1:0] off_ext;
  logic             ev_invalid, ev_limit, ev_write;

  assign off_ext    = LIN_W'(acc_off);
  assign ev_invalid = !ent_valid;
  assign ev_limit   = past_limit(off_ext, acc_word, ent_limit);
  assign ev_write   = prot_mode && acc_write && (ent_code || !ent_wr);

  always_comb begin
    acc_fault  = acc_valid && (ev_invalid || ev_limit || ev_write);
    acc_vector = 8'h00;
    if (acc_fault) begin
      if (!ev_invalid && ev_limit && (acc_seg == SEG_STACK)) acc_vector = VEC_STACK;
      else                                                   acc_vector = VEC_PROT;
    end
    acc_lin = (acc_valid && !acc_fault) ? lin_sum(ent_base, off_ext) : '0;
  end

  a_r3_word_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_word && off_ext == ent_limit) |-> acc_fault);
  a_r4_non_stack_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fault && acc_seg != SEG_STACK) |-> acc_vector == VEC_PROT);
  a_r2_no_addr_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fault |-> acc_lin == '0);
endmodule

// File: rtl/seg_shadow_unit.sv
module seg_shadow_unit
  import segchk_pkg::*;
#(
  parameter int               OFF_W         = 24,
  parameter int               PM_LAT        = 4,
  parameter logic [LIN_W-1:0] CODE_RST_BASE = 24'hFF0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prot_mode,
  input  logic             ld_valid,
  input  logic [1:0]       ld_seg,
  input  logic [15:0]      ld_sel,
  input  logic [23:0]      dsc_base,
  input  logic [23:0]      dsc_limit,
  input  logic [1:0]       dsc_dpl,
  input  logic             dsc_code,
  input  logic             dsc_writable,
  output logic             ld_busy,
  output logic             ld_done,
  output logic             ld_fault,
  output logic [7:0]       ld_vector,
  input  logic             acc_valid,
  input  logic [1:0]       acc_seg,
  input  logic [OFF_W-1:0] acc_off,
  input  logic             acc_word,
  input  logic             acc_write,
  output logic [23:0]      acc_lin,
  output logic             acc_fault,
  output logic [7:0]       acc_vector,
  output logic [1:0]       cur_cpl
);
  logic                 wr_en;
  logic [SEG_IDX_W-1:0] wr_idx;
  seg_entry_t           wr_data;
  seg_entry_t           rd_data;

  seg_load_ctrl #(.PM_LAT(PM_LAT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .prot_mode(prot_mode),
    .ld_valid(ld_valid), .ld_seg(ld_seg), .ld_sel(ld_sel),
    .dsc_base(dsc_base), .dsc_limit(dsc_limit), .dsc_dpl(dsc_dpl),
    .dsc_code(dsc_code), .dsc_writable(dsc_writable),
    .busy(ld_busy), .done(ld_done), .fault(ld_fault), .cpl(cur_cpl),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  seg_cache #(.CODE_RST_BASE(CODE_RST_BASE)) u_cache (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(acc_seg), .rd_data(rd_data),
    .ld_fault_ev(ld_fault)
  );

  seg_access_check #(.OFF_W(OFF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .prot_mode(prot_mode),
    .acc_valid(acc_valid), .acc_seg(acc_seg), .acc_off(acc_off),
    .acc_word(acc_word), .acc_write(acc_write),
    .ent_base(rd_data.base), .ent_limit(rd_data.limit),
    .ent_code(rd_data.code), .ent_wr(rd_data.wr), .ent_valid(rd_data.valid),
    .acc_lin(acc_lin), .acc_fault(acc_fault), .acc_vector(acc_vector)
  );

  assign ld_vector = ld_fault ? VEC_PROT : 8'h00;

  a_r7_load_fault_vec: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fault |-> (ld_done && ld_vector == 8'h0D));
  a_r11_cpl_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_cpl) |-> ld_done);
  a_r4_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fault |-> (acc_vector == 8'h0C || acc_vector == 8'h0D));
endmodule

// File: tb/tb_seg_shadow_unit.sv
module tb_seg_shadow_unit;
  localparam int CLK_PERIOD = 10;
  localparam int PM_LAT     = 4;
  localparam int OFF_W      = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prot_mode = 1'b0;
  logic ld_valid = 1'b0;
  logic [1:0] ld_seg = '0;
  logic [15:0] ld_sel = '0;
  logic [23:0] dsc_base = '0, dsc_limit = '0;
  logic [1:0] dsc_dpl = '0;
  logic dsc_code = 1'b0, dsc_writable = 1'b0;
  logic ld_busy, ld_done, ld_fault;
  logic [7:0] ld_vector;
  logic acc_valid = 1'b0;
  logic [1:0] acc_seg = '0;
  logic [OFF_W-1:0] acc_off = '0;
  logic acc_word = 1'b0, acc_write = 1'b0;
  logic [23:0] acc_lin;
  logic acc_fault;
  logic [7:0] acc_vector;
  logic [1:0] cur_cpl;

  seg_shadow_unit #(.OFF_W(OFF_W), .PM_LAT(PM_LAT)) dut (
    .clk(clk), .rst_n(rst_n), .prot_mode(prot_mode),
    .ld_valid(ld_valid), .ld_seg(ld_seg), .ld_sel(ld_sel),
    .dsc_base(dsc_base), .dsc_limit(dsc_limit), .dsc_dpl(dsc_dpl),
    .dsc_code(dsc_code), .dsc_writable(dsc_writable),
    .ld_busy(ld_busy), .ld_done(ld_done), .ld_fault(ld_fault), .ld_vector(ld_vector),
    .acc_valid(acc_valid), .acc_seg(acc_seg), .acc_off(acc_off),
    .acc_word(acc_word), .acc_write(acc_write),
    .acc_lin(acc_lin), .acc_fault(acc_fault), .acc_vector(acc_vector),
    .cur_cpl(cur_cpl)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_total = 0, n_fail = 0;
  bit finished = 0;

  // Reference model (segment order: extra=0, code=1, stack=2, data=3)
  longint m_base[4], m_lim[4];
  bit m_wr[4], m_code[4], m_val[4];
  int m_cpl;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_total++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Drive an access now and compare after a settle delay.
  task automatic probe(input int seg, input longint off, input bit word,
                       input bit wr, input string tag);
    bit inval, over, wp, ef;
    longint ev, el;
    acc_valid = 1'b1; acc_seg = 2'(seg); acc_off = OFF_W'(off);
    acc_word = word; acc_write = wr;
    #1;
    inval = !m_val[seg];
    over  = (off + (word ? 2 : 1)) > (m_lim[seg] + 1);
    wp    = prot_mode && wr && (m_code[seg] || !m_wr[seg]);
    ef    = inval || over || wp;
    ev    = !ef ? 0 : (!inval && over && seg == 2) ? 12 : 13;
    el    = ef ? 0 : (m_base[seg] + off) % (64'd1 << 24);
    chk({tag, " fault"}, acc_fault, ef);
    chk({tag, " vector"}, acc_vector, ev);
    chk({tag, " addr"}, acc_lin, el);
  endtask

  task automatic sweep(input int seg, input string tag);
    for (int d = -2; d <= 1; d++) begin
      longint off;
      off = m_lim[seg] + d;
      if (off >= 0 && off < (64'd1 << OFF_W)) begin
        for (int w = 0; w < 2; w++) begin
          for (int r = 0; r < 2; r++) begin
            @(negedge clk);
            probe(seg, off, w[0], r[0], tag);
          end
        end
      end
    end
    @(negedge clk);
    probe(seg, 0, 0, 0, tag);
  endtask

  task automatic do_load(input bit pm, input int seg, input int sel,
                         input longint base, input longint lim, input int dpl,
                         input bit code, input bit wr, input bit exp_fault,
                         input bit inject, input string tag);
    int nbusy;
    @(negedge clk);
    prot_mode = pm; ld_valid = 1'b1; ld_seg = 2'(seg); ld_sel = 16'(sel);
    dsc_base = 24'(base); dsc_limit = 24'(lim); dsc_dpl = 2'(dpl);
    dsc_code = code; dsc_writable = wr;
    @(negedge clk);
    ld_valid = 1'b0;
    if (!pm) begin
      chk({tag, " R5 done"}, ld_done, 1);
      chk({tag, " R5 busy"}, ld_busy, 0);
      m_base[seg] = longint'(sel) * 16; m_lim[seg] = 'hFFFF;
      m_wr[seg] = 1; m_code[seg] = 0; m_val[seg] = 1;
    end else begin
      nbusy = 0;
      while (ld_busy && nbusy <= PM_LAT + 2) begin
        nbusy++;
        if (nbusy == 1) begin
          probe(seg, 0, 0, 0, {tag, " R6 old entry while busy"});
          if (inject) begin
            ld_valid = 1'b1; ld_seg = 2'd3; ld_sel = 16'h0ABC;
          end
        end
        @(negedge clk);
        ld_valid = 1'b0;
      end
      chk({tag, " R6 busy cycles"}, nbusy, PM_LAT);
      chk({tag, " R6 done"}, ld_done, 1);
      chk({tag, " R7 fault"}, ld_fault, exp_fault);
      chk({tag, " R7 vector"}, ld_vector, exp_fault ? 13 : 0);
      if (!exp_fault) begin
        m_base[seg] = base; m_lim[seg] = lim; m_wr[seg] = wr;
        m_code[seg] = code; m_val[seg] = ((sel >> 2) != 0);
        if (seg == 1) m_cpl = dpl;
      end
    end
    chk({tag, " R11 cpl"}, cur_cpl, m_cpl);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_total++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_base[i] = 0; m_lim[i] = 'hFFFF; m_wr[i] = 1; m_code[i] = 0; m_val[i] = 1;
    end
    m_base[1] = 'hFF0000; m_cpl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", ld_busy, 0);
    chk("R1 done", ld_done, 0);
    chk("R1 cpl", cur_cpl, 0);
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      probe(s, 0, 0, 0, "R1 reset entry");
    end
    // Real-mode limit sweeps, including real writes to code (R9) and stack vector (R4)
    for (int s = 0; s < 4; s++) sweep(s, "R3 R4 R9 real sweep");

    do_load(0, 3, 'h1234, 0, 0, 0, 0, 0, 0, 0, "R5 data");
    @(negedge clk); probe(3, 'h10, 0, 0, "R2 data addr");
    do_load(0, 0, 'hFFFF, 0, 0, 0, 0, 0, 0, 0, "R5 extra");
    @(negedge clk); probe(0, 'hFFFF, 0, 0, "R2 extra top byte");

    // Protected mode
    prot_mode = 1'b1;
    do_load(1, 0, 'h0001, 'h0, 'h0, 0, 0, 1, 0, 0, "R8 null extra");
    @(negedge clk); probe(0, 0, 0, 0, "R8 invalid extra access");
    do_load(1, 0, 'h0008, 'h100000, 'h2FFFF, 0, 0, 1, 0, 1, "R6 R12 extra");
    @(negedge clk); probe(3, 'h10, 0, 0, "R12 data untouched");
    sweep(0, "R3 extra large limit");
    do_load(1, 3, 'h0013, 'h500000, 'hFFFF, 0, 0, 1, 1, 0, "R7 rpl too weak");
    @(negedge clk); probe(3, 'h10, 0, 0, "R7 data unchanged");
    do_load(1, 3, 'h0010, 'hFFFF00, 'hFFFF, 3, 0, 0, 0, 0, "R9 readonly data");
    @(negedge clk); probe(3, 'h200, 0, 0, "R2 wrap");
    sweep(3, "R9 readonly sweep");
    do_load(1, 2, 'h0018, 'h200000, 'h1FFFF, 0, 0, 1, 0, 0, "R7 stack ok");
    sweep(2, "R4 stack sweep");
    do_load(1, 2, 'h0000, 'h0, 'h0, 0, 0, 1, 1, 0, "R8 null stack");
    do_load(1, 2, 'h0018, 'h300000, 'hFF, 1, 0, 1, 1, 0, "R7 stack dpl");
    do_load(1, 1, 'h0022, 'h300000, 'hFFF, 2, 1, 0, 0, 0, "R11 code");
    @(negedge clk); probe(1, 0, 0, 1, "R9 code write");
    sweep(1, "R9 code sweep");
    do_load(1, 3, 'h0028, 'h400000, 'hFF, 1, 0, 1, 1, 0, "R7 R11 outer dpl");
    do_load(1, 1, 'h0022, 'h300000, 'hFFF, 2, 0, 0, 1, 0, "R7 code type");

    // Back to real mode
    prot_mode = 1'b0;
    @(negedge clk); probe(0, 'h20000, 1, 0, "R10 kept limit");
    sweep(0, "R10 kept sweep");
    @(negedge clk); probe(3, 'h10, 0, 1, "R9 real write readonly");
    do_load(0, 0, 'h0100, 0, 0, 0, 0, 0, 0, 0, "R10 reload extra");
    @(negedge clk); probe(0, 'h20000, 0, 0, "R10 after reload");
    @(negedge clk); probe(0, 'hFFFF, 1, 0, "R3 word at FFFF");

    acc_valid = 1'b0;
    finished = 1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule